// File: doc/BRIEF.md
# Emulation Control Scan Decoder

This block is an extended data-register path behind a JTAG TAP. It gives an external debugger access to a small on-chip emulation unit. The TAP controller is not part of the block. It is modelled by single-cycle strobes:

- an instruction update with its code;
- Capture-DR, Shift-DR and Update-DR.

These strobes all run in the block's clock domain.

Selecting the emulation instruction makes every DR scan alternate between two phases:

- **Control phase.** A scan loads a 10-bit control word. That word states whether the next scan reads or writes, whether the core must execute the command register afterwards, whether the core must leave debug mode, and which emulation register takes part.
- **Data phase.** The following scan performs that access.

A write to the core command register with the execute flag set hands the shifted instruction word to the core. Results come back through a transmit register that the core loads and the debugger shifts out. The control-phase capture returns a status word, so the debugger can poll the core state on every control scan. Two further instruction codes are provided:

- a plain status scan;
- a one-cycle debug request to the core.

Top module: `emu_scan_ctl`

## Requirements
- R1: After reset, tdo, exec_strobe, exit_debug and debug_req are low. The transmit register is empty. No instruction is selected, so a DR scan shifts out zeros.
- R2: Data enters on tdi least-significant bit first. A control word is the last 10 bits shifted in. Its fields are: bit 9 read (1) or write (0), bit 8 execute, bit 7 exit debug, bits 6:0 register offset. For example, 0x17E means write, execute, stay in debug mode, offset 0x7E.
- R3: The Capture-DR of a control-phase scan loads the status word, which leaves on tdo least-significant bit first. Bit 0 is core_in_debug, bit 1 is transmit-full, and all other bits are 0.
- R4: An instruction update with code 0x6 selects the emulation path and forces the next scan to be a control scan. After that, emulation Update-DRs alternate strictly between control and data.
- R5: A data phase whose control word has the execute flag set pulses exec_strobe for one cycle, in the cycle after its Update-DR. At that time exec_word holds the command register (offset 0x7E), including any value written by the same scan. A write to 0x7E without the execute flag only stores the word.
- R6: exit_debug pulses for one cycle, in the same cycle exec_strobe would pulse, only when the exit flag of the control word is set.
- R7: A read of offset 0x7D captures the transmit register at the data-phase Capture-DR and shifts it out. Its Update-DR clears transmit-full.
- R8: core_xmit_we loads core_xmit_data into the transmit register and sets transmit-full. If it falls in the same cycle as a clearing Update-DR, the flag stays set and the new value is kept.
- R9: A data-phase read of offset 0x7E returns the command register. A read of any offset other than 0x7E and 0x7D returns zero. Writes to 0x7D or to unknown offsets change nothing, and a write scan captures zero.
- R10: Instruction code 0x8 pulses debug_req for one cycle after its update. Code 0x7 makes every DR scan capture the status word and leaves the emulation phase untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_update | input | 1 | Instruction update strobe |
| ir_code | input | IR_W | Instruction code presented with ir_update |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe, one bit per cycle |
| update_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| core_in_debug | input | 1 | Core reports that it is in debug mode |
| core_xmit_we | input | 1 | Core loads the transmit register |
| core_xmit_data | input | DATA_W | Value the core loads |
| exec_strobe | output | 1 | Execute the command word |
| exec_word | output | DATA_W | Command register contents |
| exit_debug | output | 1 | Request to leave debug mode |
| debug_req | output | 1 | Debug request to the core |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a core load of the transmit register and the debugger's read-completing Update-DR. The bench provokes this by raising core_xmit_we in the exact cycle of that Update-DR. The next control scan must then still show transmit-full, and a further read must return the new word.

The second pair is exec_strobe and exit_debug, which share a cycle when a control word sets both flags. The bench samples both outputs one cycle after the Update-DR and compares them with its own decode of the control word. This comparison also runs under seeded random control words and data.

// File: rtl/emu_scan_pkg.sv
package emu_scan_pkg;
  localparam int CTL_W = 10;
  localparam int OFS_W = 7;
  localparam logic [OFS_W-1:0] CMD_OFS  = 7'h7E;
  localparam logic [OFS_W-1:0] XMIT_OFS = 7'h7D;

  typedef struct packed {
    logic             rd;
    logic             ex;
    logic             quit;
    logic [OFS_W-1:0] ofs;
  } ctl_t;

  // split a raw control word into its fields
  function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] w);
    ctl_t c;
    c.rd   = w[9];
    c.ex   = w[8];
    c.quit = w[7];
    c.ofs  = w[OFS_W-1:0];
    return c;
  endfunction

  // two-bit status: transmit-full above debug-mode
  function automatic logic [1:0] status_bits(input logic dbg, input logic full);
    return {full, dbg};
  endfunction
endpackage

// File: rtl/emu_shift.sv
module emu_shift #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              shift,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_val,
  output logic [DATA_W-1:0] sr,
  output logic              tdo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr <= '0;
    else if (capture) sr <= cap_val;
    else if (shift)   sr <= {tdi, sr[DATA_W-1:1]};
  end

  assign tdo = sr[0];
endmodule

// File: rtl/emu_phase.sv
module emu_phase
  import emu_scan_pkg::*;
#(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] IR_EMU    = 4'h6,
  parameter logic [IR_W-1:0] IR_STATUS = 4'h7,
  parameter logic [IR_W-1:0] IR_DBGREQ = 4'h8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_update,
  input  logic [IR_W-1:0]  ir_code,
  input  logic             update_dr,
  input  logic [CTL_W-1:0] sr_top,
  output logic             sel_emu,
  output logic             sel_status,
  output logic             in_data,
  output ctl_t             ctl,
  output logic             ctrl_done,
  output logic             data_done,
  output logic             debug_req
);
  logic [IR_W-1:0] ir_q;

  assign sel_emu    = (ir_q == IR_EMU);
  assign sel_status = (ir_q == IR_STATUS);
  assign ctrl_done  = update_dr && sel_emu && !in_data;
  assign data_done  = update_dr && sel_emu && in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q      <= '0;
      in_data   <= 1'b0;
      ctl       <= '0;
      debug_req <= 1'b0;
    end else begin
      debug_req <= ir_update && (ir_code == IR_DBGREQ);
      if (ir_update) begin
        ir_q    <= ir_code;
        in_data <= 1'b0;
      end else if (ctrl_done) begin
        ctl     <= decode_ctl(sr_top);
        in_data <= 1'b1;
      end else if (data_done) begin
        in_data <= 1'b0;
      end
    end
  end

  a_r4_data_after_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_done && !ir_update) |=> in_data);
  a_r4_ctrl_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    data_done |=> !in_data);
  a_r4_reselect_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ir_update |=> !in_data);
endmodule

// File: rtl/emu_regs.sv
module emu_regs
  import emu_scan_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_done,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] din,
  input  logic              core_xmit_we,
  input  logic [DATA_W-1:0] core_xmit_data,
  output logic [DATA_W-1:0] cmd_q,
  output logic              xmit_full,
  output logic [DATA_W-1:0] rd_val,
  output logic              exec_q,
  output logic              exit_q
);
  logic [DATA_W-1:0] xmit_q;
  logic cmd_wr, xmit_rd_done;

  assign cmd_wr       = data_done && !ctl.rd && (ctl.ofs == CMD_OFS);
  assign xmit_rd_done = data_done && ctl.rd && (ctl.ofs == XMIT_OFS);

  always_comb begin
    case (ctl.ofs)
      CMD_OFS:  rd_val = cmd_q;
      XMIT_OFS: rd_val = xmit_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      xmit_q    <= '0;
      xmit_full <= 1'b0;
      exec_q    <= 1'b0;
      exit_q    <= 1'b0;
    end else begin
      exec_q <= data_done && ctl.ex;
      exit_q <= data_done && ctl.quit;
      if (cmd_wr) cmd_q <= din;
      if (core_xmit_we) begin
        xmit_q    <= core_xmit_data;
        xmit_full <= 1'b1;
      end else if (xmit_rd_done) begin
        xmit_full <= 1'b0;
      end
    end
  end

  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd_q));
  a_r8_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
    core_xmit_we |=> xmit_full);
  a_r7_full_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_rd_done && !core_xmit_we) |=> !xmit_full);
  a_r9_xmit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !core_xmit_we |=> $stable(xmit_q));
endmodule

// File: rtl/emu_scan_ctl.sv
module emu_scan_ctl
  import emu_scan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IR_W   = 4,
  parameter logic [IR_W-1:0] IR_EMU    = 4'h6,
  parameter logic [IR_W-1:0] IR_STATUS = 4'h7,
  parameter logic [IR_W-1:0] IR_DBGREQ = 4'h8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_update,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              core_in_debug,
  input  logic              core_xmit_we,
  input  logic [DATA_W-1:0] core_xmit_data,
  output logic              exec_strobe,
  output logic [DATA_W-1:0] exec_word,
  output logic              exit_debug,
  output logic              debug_req
);
  logic [DATA_W-1:0] sr, cap_val, rd_val;
  logic sel_emu, sel_status, in_data, ctrl_done, data_done, xmit_full;
  ctl_t ctl;

  always_comb begin
    if (sel_status || (sel_emu && !in_data))
      cap_val = {{(DATA_W-2){1'b0}}, status_bits(core_in_debug, xmit_full)};
    else if (sel_emu && ctl.rd)
      cap_val = rd_val;
    else
      cap_val = '0;
  end

  emu_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .capture(capture_dr), .shift(shift_dr),
    .tdi(tdi), .cap_val(cap_val), .sr(sr), .tdo(tdo)
  );

  emu_phase #(.IR_W(IR_W), .IR_EMU(IR_EMU), .IR_STATUS(IR_STATUS),
              .IR_DBGREQ(IR_DBGREQ)) u_phase (
    .clk(clk), .rst_n(rst_n), .ir_update(ir_update), .ir_code(ir_code),
    .update_dr(update_dr), .sr_top(sr[DATA_W-1 -: CTL_W]),
    .sel_emu(sel_emu), .sel_status(sel_status), .in_data(in_data), .ctl(ctl),
    .ctrl_done(ctrl_done), .data_done(data_done), .debug_req(debug_req)
  );

  emu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_done(data_done), .ctl(ctl), .din(sr),
    .core_xmit_we(core_xmit_we), .core_xmit_data(core_xmit_data),
    .cmd_q(exec_word), .xmit_full(xmit_full), .rd_val(rd_val),
    .exec_q(exec_strobe), .exit_q(exit_debug)
  );

  a_r5_exec_single: assert property (@(posedge clk) disable iff (!rst_n)
    exec_strobe |=> !exec_strobe);
  a_r6_exit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    exit_debug |-> $past(ctl.quit));
  a_r10_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    debug_req |=> !debug_req);
  a_r3_ctrl_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_done |=> !exec_strobe && !exit_debug);
endmodule

// File: tb/emu_scan_ctl_tb.sv
`timescale 1ns/1ps
module emu_scan_ctl_tb;
  localparam logic [3:0] IR_EMU = 4'h6, IR_STATUS = 4'h7, IR_DBGREQ = 4'h8;

  logic clk = 0, rst_n = 0;
  logic ir_update = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic [3:0] ir_code = '0;
  logic core_in_debug = 0, core_xmit_we = 0;
  logic [31:0] core_xmit_data = '0;
  logic tdo, exec_strobe, exit_debug, debug_req;
  logic [31:0] exec_word;

  int errors = 0, checks = 0;
  logic ex_seen, exit_seen, req_seen;
  logic [31:0] word_seen;
  logic [31:0] cmd_m = '0, xmit_m = '0;
  logic full_m = 0;

  always #4 clk = ~clk;

  emu_scan_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .ir_update(ir_update), .ir_code(ir_code),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .core_in_debug(core_in_debug),
    .core_xmit_we(core_xmit_we), .core_xmit_data(core_xmit_data),
    .exec_strobe(exec_strobe), .exec_word(exec_word),
    .exit_debug(exit_debug), .debug_req(debug_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] status_exp(input logic dbg, input logic full);
    return 32'(dbg) | (32'(full) << 1);
  endfunction

  task automatic ir_load(input logic [3:0] code);
    @(negedge clk); ir_code = code; ir_update = 1;
    @(negedge clk); ir_update = 0; req_seen = debug_req;
  endtask

  task automatic core_load(input logic [31:0] v);
    @(negedge clk); core_xmit_we = 1; core_xmit_data = v;
    @(negedge clk); core_xmit_we = 0;
    xmit_m = v; full_m = 1;
  endtask

  task automatic dr_scan(input int len, input logic [31:0] din, input logic coll,
                         input logic [31:0] cval, output logic [31:0] dout);
    dout = '0;
    @(negedge clk); capture_dr = 1;
    @(negedge clk); capture_dr = 0;
    for (int i = 0; i < len; i++) begin
      tdi = din[i]; shift_dr = 1; dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    if (coll) begin core_xmit_we = 1; core_xmit_data = cval; end
    @(negedge clk);
    update_dr = 0; core_xmit_we = 0;
    ex_seen = exec_strobe; exit_seen = exit_debug; word_seen = exec_word;
  endtask

  // one control scan plus one data scan, checked against the bench model
  task automatic access(input logic [9:0] cw, input logic [31:0] din, input string tag);
    logic [31:0] so, exp_rd;
    logic rd, ex, qt;
    logic [6:0] ofs;
    rd = cw[9]; ex = cw[8]; qt = cw[7]; ofs = cw[6:0];
    dr_scan(10, {22'b0, cw}, 0, '0, so);
    chk({tag, " R3 status"}, so & 32'h3FF, status_exp(core_in_debug, full_m));
    chk({tag, " R3 ctl no strobe"}, {30'b0, ex_seen, exit_seen}, 32'b0);
    if (!rd) exp_rd = '0;
    else if (ofs == 7'h7E) exp_rd = cmd_m;
    else if (ofs == 7'h7D) exp_rd = xmit_m;
    else exp_rd = '0;
    dr_scan(32, din, 0, '0, so);
    chk({tag, " R9 data capture"}, so, exp_rd);
    if (!rd && ofs == 7'h7E) cmd_m = din;
    if (rd && ofs == 7'h7D) full_m = 0;
    chk({tag, " R5 exec"}, 32'(ex_seen), 32'(ex));
    chk({tag, " R6 exit"}, 32'(exit_seen), 32'(qt));
    if (ex) chk({tag, " R5 word"}, word_seen, cmd_m);
  endtask

  initial begin
    #(8ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] so;
    void'($urandom(32'd1234));
    #20; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tdo", 32'(tdo), 0);
    chk("R1 strobes", {29'b0, exec_strobe, exit_debug, debug_req}, 0);
    dr_scan(32, 32'hFFFF_FFFF, 0, '0, so);
    chk("R1 no selection shifts zero", so, 0);

    // R10 debug request
    ir_load(IR_DBGREQ);
    chk("R10 debug_req pulse", 32'(req_seen), 1);
    @(negedge clk);
    chk("R10 debug_req one cycle", 32'(debug_req), 0);

    core_in_debug = 1;
    ir_load(IR_EMU);
    // R2/R5: 0x17E write exec stay
    access(10'h17E, 32'hA5A5_1234, "R2 stuff");
    // R6 both flags
    access(10'h1FE, 32'h0BAD_F00D, "R6 exec+exit");
    // R5 write without exec, read back
    access(10'h07E, 32'h1357_9BDF, "R5 store");
    access(10'h27E, 32'h0, "R9 cmd read");
    // R7/R8 transmit path
    core_load(32'hCAFE_0001);
    access(10'h27D, 32'h0, "R7 xmit read");
    // R9 writes to xmit and unknown ignored
    core_load(32'h1111_2222);
    access(10'h07D, 32'hDEAD_BEEF, "R9 xmit write");
    access(10'h005, 32'hDEAD_BEEF, "R9 unk write");
    access(10'h205, 32'h0, "R9 unk read");
    access(10'h27D, 32'h0, "R9 xmit kept");

    // R8 collision: core loads in the clearing cycle
    core_load(32'h0000_AAAA);
    dr_scan(10, 32'h27D, 0, '0, so);
    dr_scan(32, 32'h0, 1, 32'h5555_0000, so);
    chk("R8 collision read", so, 32'h0000_AAAA);
    xmit_m = 32'h5555_0000; full_m = 1;
    access(10'h27D, 32'h0, "R8 new value");

    // R10 status instruction; R4 reselect resets phase
    ir_load(IR_EMU);
    dr_scan(10, 32'h07E, 0, '0, so);
    core_load(32'h7777_0000);
    ir_load(IR_STATUS);
    dr_scan(32, 32'h0, 0, '0, so);
    chk("R10 status scan", so, status_exp(1, 1));
    dr_scan(32, 32'h0, 0, '0, so);
    chk("R10 status again", so, status_exp(1, 1));
    chk("R10 no exec", 32'(ex_seen), 0);
    ir_load(IR_EMU);
    access(10'h17E, 32'h4242_4242, "R4 reselect ctrl");

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [9:0] cw;
      logic [31:0] d;
      cw = 10'($urandom);
      case ($urandom % 3)
        0: cw[6:0] = 7'h7E;
        1: cw[6:0] = 7'h7D;
        default: ;
      endcase
      d = $urandom;
      core_in_debug = 1'($urandom);
      if (($urandom % 3) == 0) core_load($urandom);
      access(cw, d, "R5 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule